// File: doc/BRIEF.md
# Indexed Load/Store Address Generator

This block forms the memory address for a single load or store and, when the addressing mode asks for it, the new value to be written back into the base register. It takes a base register value and one of three offset forms (a 12-bit unsigned immediate, a register value, or a register value shifted left by a 5-bit amount). The offset is added to or subtracted from the base as an up/down bit selects. Three addressing modes are supported: pre-index without base update, pre-index with base update, and post-index. In post-index mode the access uses the unmodified base and the base is always updated.

The result is checked for natural alignment against the access size (byte, halfword or word). A misaligned access raises a fault flag and suppresses the base update. The block is a single registered stage: a request presented with `req_vld` high appears on the outputs one clock later with `rsp_vld` high. All arithmetic is 32 bits and wraps modulo 2^32 with no overflow indication.

Top module: `lsu_agu`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, `rsp_vld`, `upd_en` and `mis_flt` are 0.
- R2: `rsp_vld` equals the value `req_vld` had at the previous rising clock edge. The other outputs describe the request captured at that same edge.
- R3: The offset source is chosen by `off_kind`: 00 selects `imm_off` zero-extended to 32 bits, 01 selects `idx_val`, and 10 or 11 selects `idx_val` shifted left by `sh_amt`, with bits shifted past bit 31 discarded.
- R4: With `up_dn` = 1 the offset is added to `base_val`; with `up_dn` = 0 it is subtracted. The result wraps modulo 2^32 for every offset form.
- R5: With `pre_mode` = 1, `acc_addr` and `upd_val` both equal the base-plus-or-minus-offset sum, and `upd_en` follows `upd_req` (when aligned).
- R6: With `pre_mode` = 0 (post-index), `acc_addr` equals the unmodified `base_val`, `upd_val` equals the sum, and `upd_en` is 1 whatever `upd_req` is (when aligned).
- R7: Alignment is judged on `acc_addr` using `acc_sz`. 00 (byte) never faults. 01 (halfword) faults when bit 0 is 1. 10 or 11 (word) faults when bits 1:0 are not 00.
- R8: A misaligned access sets `mis_flt` and forces `upd_en` to 0, while `acc_addr` and `upd_val` still carry the computed values.
- R9: When `rsp_vld` is 0, `upd_en` and `mis_flt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid |
| base_val | input | 32 | Base register value |
| idx_val | input | 32 | Offset register value |
| imm_off | input | 12 | Unsigned immediate offset |
| off_kind | input | 2 | Offset form select (R3) |
| sh_amt | input | 5 | Left-shift amount for the scaled register form |
| up_dn | input | 1 | 1 adds the offset, 0 subtracts it |
| acc_sz | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| pre_mode | input | 1 | 1 pre-index, 0 post-index |
| upd_req | input | 1 | Base update request for pre-index mode |
| rsp_vld | output | 1 | Result valid, one cycle after `req_vld` |
| acc_addr | output | 32 | Memory access address |
| upd_en | output | 1 | Base register update enable |
| upd_val | output | 32 | New base register value |
| mis_flt | output | 1 | Alignment fault |

## Verification
The clocked properties assume that `req_vld` is low while `rst` is high. They also assume that mode and base inputs are meaningful only in cycles where `req_vld` is high. The stimulus holds `req_vld` low throughout reset and drives every input from the negative clock edge, so each request is stable across the capturing edge. Idle cycles are mixed in with random request fields, so the quiet-output rules are exercised with non-zero data on the other inputs. Directed vectors cover wraparound, the widest shift, the largest immediate, and misaligned post-index accesses.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [1:0] {
    OFF_IMM   = 2'b00,
    OFF_REG   = 2'b01,
    OFF_SHL   = 2'b10,
    OFF_SHL_B = 2'b11
  } off_kind_e;

  typedef enum logic [1:0] {
    SZ_BYTE   = 2'b00,
    SZ_HALF   = 2'b01,
    SZ_WORD   = 2'b10,
    SZ_WORD_B = 2'b11
  } acc_sz_e;
endpackage

// File: rtl/agu_offset.sv
module agu_offset #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic [1:0]        kind,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] idx,
  input  logic [SH_W-1:0]   sh,
  output logic [DATA_W-1:0] off
);
  import agu_pkg::*;
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] idx_shl;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_ext = {{PAD_W{1'b0}}, imm};
    end else begin : g_nopad
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign idx_shl = idx << sh;

  always_comb begin
    unique case (off_kind_e'(kind))
      OFF_IMM:           off = imm_ext;
      OFF_REG:           off = idx;
      OFF_SHL, OFF_SHL_B: off = idx_shl;
      default:           off = idx;
    endcase
  end
endmodule

// File: rtl/agu_sum.sv
module agu_sum #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] base,
  input  logic [DATA_W-1:0] off,
  input  logic              up,
  output logic [DATA_W-1:0] sum
);
  logic [DATA_W-1:0] opnd;
  logic              cin;

  // Subtraction reuses the adder: base + ~off + 1
  assign opnd = up ? off : ~off;
  assign cin  = ~up;
  assign sum  = base + opnd + {{(DATA_W-1){1'b0}}, cin};
endmodule

// File: rtl/agu_align.sv
module agu_align #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] addr,
  input  logic [1:0]        sz,
  output logic              flt
);
  import agu_pkg::*;

  always_comb begin
    unique case (acc_sz_e'(sz))
      SZ_BYTE:             flt = 1'b0;
      SZ_HALF:             flt = addr[0];
      SZ_WORD, SZ_WORD_B:  flt = |addr[1:0];
      default:             flt = 1'b0;
    endcase
  end

  // R7: byte accesses may use any address
  always_comb begin
    if (sz == 2'b00) begin
      a_r7_byte_never: assert (!flt);
    end
  end
endmodule

// File: rtl/lsu_agu.sv
module lsu_agu #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  parameter int SH_W   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_vld,
  input  logic [DATA_W-1:0] base_val,
  input  logic [DATA_W-1:0] idx_val,
  input  logic [IMM_W-1:0]  imm_off,
  input  logic [1:0]        off_kind,
  input  logic [SH_W-1:0]   sh_amt,
  input  logic              up_dn,
  input  logic [1:0]        acc_sz,
  input  logic              pre_mode,
  input  logic              upd_req,
  output logic              rsp_vld,
  output logic [DATA_W-1:0] acc_addr,
  output logic              upd_en,
  output logic [DATA_W-1:0] upd_val,
  output logic              mis_flt
);
  logic [DATA_W-1:0] off_w;
  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] addr_w;
  logic              flt_w;
  logic              want_upd;

  agu_offset #(.DATA_W(DATA_W), .IMM_W(IMM_W), .SH_W(SH_W)) i_off (
    .kind (off_kind),
    .imm  (imm_off),
    .idx  (idx_val),
    .sh   (sh_amt),
    .off  (off_w)
  );

  agu_sum #(.DATA_W(DATA_W)) i_sum (
    .base (base_val),
    .off  (off_w),
    .up   (up_dn),
    .sum  (sum_w)
  );

  assign addr_w   = pre_mode ? sum_w : base_val;
  assign want_upd = upd_req | ~pre_mode;

  agu_align #(.DATA_W(DATA_W)) i_aln (
    .addr (addr_w),
    .sz   (acc_sz),
    .flt  (flt_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_vld  <= 1'b0;
      upd_en   <= 1'b0;
      mis_flt  <= 1'b0;
      acc_addr <= '0;
      upd_val  <= '0;
    end else begin
      rsp_vld  <= req_vld;
      upd_en   <= req_vld & want_upd & ~flt_w;
      mis_flt  <= req_vld & flt_w;
      acc_addr <= addr_w;
      upd_val  <= sum_w;
    end
  end

  // R1: outputs quiet after a reset edge
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!rsp_vld && !upd_en && !mis_flt));

  // R2: one-cycle valid latency
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rsp_vld == $past(req_vld)));

  // R5: pre-index reports the same sum as address and update value
  a_r5_pre_same: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_vld && $past(pre_mode)) |-> (acc_addr == upd_val));

  // R6: post-index accesses the unmodified base
  a_r6_post_addr: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_vld && !$past(pre_mode)) |-> (acc_addr == $past(base_val)));

  // R6: post-index always updates when aligned
  a_r6_post_writes: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && rsp_vld && !mis_flt && !$past(pre_mode)) |-> upd_en);

  // R8: fault blocks the update
  a_r8_fault_blocks: assert property (@(posedge clk) disable iff (rst)
    (rsp_vld && mis_flt) |-> !upd_en);

  // R9: idle outputs stay quiet
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_vld |-> (!upd_en && !mis_flt));
endmodule

// File: tb/test_lsu_agu.sv
module test_lsu_agu;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_vld = 1'b0;
  logic [31:0] base_val = '0;
  logic [31:0] idx_val = '0;
  logic [11:0] imm_off = '0;
  logic [1:0]  off_kind = '0;
  logic [4:0]  sh_amt = '0;
  logic        up_dn = 1'b0;
  logic [1:0]  acc_sz = '0;
  logic        pre_mode = 1'b0;
  logic        upd_req = 1'b0;
  logic        rsp_vld;
  logic [31:0] acc_addr;
  logic        upd_en;
  logic [31:0] upd_val;
  logic        mis_flt;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // expected values for the response due at the next check
  bit          e_vld = 0;
  logic [31:0] e_addr, e_val;
  bit          e_en, e_flt, e_pre;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsu_agu i_lsu_agu (
    .clk(clk), .rst(rst), .req_vld(req_vld), .base_val(base_val),
    .idx_val(idx_val), .imm_off(imm_off), .off_kind(off_kind),
    .sh_amt(sh_amt), .up_dn(up_dn), .acc_sz(acc_sz), .pre_mode(pre_mode),
    .upd_req(upd_req), .rsp_vld(rsp_vld), .acc_addr(acc_addr),
    .upd_en(upd_en), .upd_val(upd_val), .mis_flt(mis_flt)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_rsp();
    chk("R2", "rsp_vld", {31'b0, rsp_vld}, {31'b0, e_vld});
    if (!e_vld) begin
      chk("R9", "upd_en idle", {31'b0, upd_en}, 32'd0);
      chk("R9", "mis_flt idle", {31'b0, mis_flt}, 32'd0);
    end else begin
      chk(e_pre ? "R5" : "R6", "acc_addr", acc_addr, e_addr);
      chk("R4", "upd_val", upd_val, e_val);
      chk("R7", "mis_flt", {31'b0, mis_flt}, {31'b0, e_flt});
      chk(e_flt ? "R8" : (e_pre ? "R5" : "R6"), "upd_en",
          {31'b0, upd_en}, {31'b0, e_en});
    end
  endtask

  // Behavioural reference model; drives one request at a negedge
  task automatic apply(input bit v, input logic [31:0] b, input logic [31:0] x,
                       input logic [11:0] im, input logic [1:0] k,
                       input logic [4:0] s, input bit u, input logic [1:0] sz,
                       input bit p, input bit w);
    longint unsigned off, sum;
    logic [31:0] a;
    bit f;
    @(negedge clk);
    check_rsp();
    req_vld = v; base_val = b; idx_val = x; imm_off = im; off_kind = k;
    sh_amt = s; up_dn = u; acc_sz = sz; pre_mode = p; upd_req = w;
    // R3: offset forms
    if (k == 2'd0)      off = longint'(im);
    else if (k == 2'd1) off = longint'(x);
    else                off = (longint'(x) * (64'd1 << s)) % 64'h1_0000_0000;
    // R4: modulo 2^32 add or subtract
    if (u) sum = (longint'(b) + off) % 64'h1_0000_0000;
    else   sum = (longint'(b) + 64'h1_0000_0000 - off) % 64'h1_0000_0000;
    a = p ? sum[31:0] : b;
    if (sz == 2'd0)      f = 0;
    else if (sz == 2'd1) f = (a % 2) != 0;
    else                 f = (a % 4) != 0;
    e_vld = v; e_addr = a; e_val = sum[31:0]; e_flt = f; e_pre = p;
    e_en = (p ? w : 1'b1) && !f;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "rsp_vld reset", {31'b0, rsp_vld}, 32'd0);
    chk("R1", "upd_en reset", {31'b0, upd_en}, 32'd0);
    chk("R1", "mis_flt reset", {31'b0, mis_flt}, 32'd0);
    rst = 1'b0;

    // R5 pre-index, immediate, no update
    apply(1, 32'h0000_1000, 32'h0, 12'h004, 2'd0, 5'd0, 1, 2'd2, 1, 0);
    // R5 pre-index with update, register offset, subtract
    apply(1, 32'h0000_1000, 32'h10, 12'h0, 2'd1, 5'd0, 0, 2'd2, 1, 1);
    // R6 post-index with upd_req low still updates
    apply(1, 32'h0000_2000, 32'h0, 12'h008, 2'd0, 5'd0, 1, 2'd2, 0, 0);
    // R3 scaled register, widest shift
    apply(1, 32'h0000_0000, 32'h0000_0003, 12'h0, 2'd2, 5'd31, 1, 2'd0, 1, 1);
    // R3 code 11 also scaled
    apply(1, 32'h0000_0100, 32'h0000_0005, 12'h0, 2'd3, 5'd2, 1, 2'd2, 1, 1);
    // R4 wraparound on add and subtract
    apply(1, 32'hFFFF_FFFC, 32'h0, 12'h008, 2'd0, 5'd0, 1, 2'd2, 1, 1);
    apply(1, 32'h0000_0004, 32'h0, 12'hFFF, 2'd0, 5'd0, 0, 2'd0, 1, 1);
    // R7/R8 misaligned halfword and word, pre and post
    apply(1, 32'h0000_1001, 32'h0, 12'h0, 2'd0, 5'd0, 1, 2'd1, 1, 1);
    apply(1, 32'h0000_1002, 32'h0, 12'h4, 2'd0, 5'd0, 1, 2'd2, 0, 1);
    apply(1, 32'h0000_1000, 32'h0, 12'h2, 2'd0, 5'd0, 1, 2'd1, 0, 0);
    // R7 byte at odd address never faults
    apply(1, 32'h0000_1003, 32'h0, 12'h0, 2'd0, 5'd0, 1, 2'd0, 0, 0);
    // R9 idle with busy inputs
    apply(0, 32'h0000_1003, 32'h0, 12'h1, 2'd0, 5'd0, 1, 2'd2, 0, 1);

    for (int i = 0; i < 3000; i++) begin
      apply(($urandom % 4) != 0, $urandom, $urandom, 12'($urandom),
            2'($urandom), 5'($urandom), 1'($urandom), 2'($urandom),
            1'($urandom), 1'($urandom));
    end
    apply(0, 32'h0, 32'h0, 12'h0, 2'd0, 5'd0, 0, 2'd0, 0, 0);
    @(negedge clk);
    check_rsp();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule